// File: doc/BRIEF.md
# Receive Destination Filter with Alternating Frame Buffers

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per cycle on a valid/last byte stream. The block compares the destination address in the first six bytes against the programmed station address. Frames that pass are packed into 32-bit words and written into one of two on-chip frame buffers. A frame is dropped without trace if it fails the check, is shorter than a header, or is too long for a buffer.

Each buffer owns a 32-bit control word. Bit 0 of that word flags the buffer as holding an unread frame. Software reads the frame through a word-addressed port and then writes bit 0 back to 0 to hand the buffer back. In alternating mode the two buffers take turns. Otherwise buffer 0 receives every frame.

A frame that arrives while the target buffer is still held is lost and reported by a pulse. A stored frame can raise a one-cycle interrupt pulse, gated by bit 3 of buffer 0's control word and a global enable.

Top module: `ethrx_pingpong_rx`

## Requirements
- R1: After a synchronous active-low reset, both control words read 0, `rx_irq` and `rx_lost` are low, and buffer 0 is the first target.
- R2: A frame whose first byte has bit 7 set (group address) is stored, whatever its other destination bytes.
- R3: A frame whose first byte has bit 7 clear is stored only if its first six bytes equal `station_mac`, with `station_mac[47:40]` compared to the first byte. Any other frame is discarded, leaving both control words and the target buffer unchanged.
- R4: If bit 0 of the target buffer's control word is 1 when a frame's first byte arrives, the frame is lost. In that case `rx_lost` is high for exactly the cycle after that byte, no frame data is written, and the control words and target stay as they were.
- R5: With CAP = BUF_BYTES-4, a frame of CAP bytes is stored, and a frame of CAP+1 or more bytes is discarded with no change to the control words or target. Frame data never overwrites a control word.
- R6: When a frame is stored, bit 0 of the target buffer's control word becomes 1. A read issued on the next cycle returns it.
- R7: `rx_irq` is high for exactly the cycle after the last byte of a stored frame, and only if bit 3 of buffer 0's control word and `gie_en` are both 1. This holds whichever buffer took the frame.
- R8: With `pp_en`=1 the target buffer alternates after every stored frame. With `pp_en`=0 every frame goes to buffer 0.
- R9: Byte n of a stored frame of buffer b sits in data word n/4 of that buffer, in lane n mod 4 (lane 0 = bits 7:0). A final partial word is written with its unfilled upper lanes set to zero.
- R10: A write to a control word stores all 32 bits as given. Writing bit 0 as 0 releases the buffer, and the next frame that targets it is stored.
- R11: A frame shorter than six bytes is discarded, even when its first byte has bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| station_mac | input | 48 | Station address; bits 47:40 are the first byte on the wire |
| pp_en | input | 1 | 1 = buffers alternate, 0 = buffer 0 only; held static between resets |
| gie_en | input | 1 | Global interrupt enable |
| rx_valid | input | 1 | A frame byte is present on `rx_data` |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| bus_word | input | $clog2(BUF_BYTES/4)+1 | Word address; top bit selects the buffer, an all-ones low part selects that buffer's control word |
| bus_wr | input | 1 | Write strobe; only control words are writable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_word` |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| rx_lost | output | 1 | One-cycle pulse for a frame lost to a held buffer |

## Verification
A wrong target index shows on the next stored frame, as bit 0 set in the wrong control word. It can stay hidden while both buffers are free, so the bench fills and releases each buffer in turn. A corrupted filter or length state shows as a missing or extra `rx_irq` pulse in the cycle after the frame's last byte. A corrupted packing accumulator shows only when the stored words are read back, so every committed frame is read back word by word. Because the model is compared every clock, a stuck or doubled pulse is caught within one cycle.

// File: rtl/ethrx_pkg.sv
// Shared constants and types for the receive frame-buffer block.
// Assumes 32-bit control words and a 6-byte destination address.
package ethrx_pkg;
    localparam int STAT_BIT   = 0;   // buffer-held flag in a control word
    localparam int IEN_BIT    = 3;   // receive interrupt enable (buffer 0 only)
    localparam int ADDR_BYTES = 6;   // destination address length

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_STORE,
        FR_DROP
    } frame_st_e;
endpackage

// File: rtl/rx_dest_filter.sv
// Destination address check.
// Walks the first six bytes of a frame. Reports pass at byte index 5 when the
// group bit of byte 0 is set, or when all six bytes match the station address.
// Assumes idx_i saturates at 7 and that byte_v_i marks bytes that are kept.
module rx_dest_filter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_v_i,
    input  logic [2:0]  idx_i,
    input  logic [7:0]  byte_i,
    input  logic [47:0] mac_i,
    output logic        pass_o
);
    logic       grp_q;
    logic       eq_q;
    logic       grp_now;
    logic       eq_now;
    logic [7:0] ref_b;

    // Select the station address byte matching the current position.
    always_comb begin
        case (idx_i)
            3'd0:    ref_b = mac_i[47:40];
            3'd1:    ref_b = mac_i[39:32];
            3'd2:    ref_b = mac_i[31:24];
            3'd3:    ref_b = mac_i[23:16];
            3'd4:    ref_b = mac_i[15:8];
            3'd5:    ref_b = mac_i[7:0];
            default: ref_b = 8'h00;
        endcase
    end

    // Combine this byte with the running match state.
    always_comb begin
        grp_now = (idx_i == 3'd0) ? byte_i[7] : grp_q;
        eq_now  = ((idx_i == 3'd0) ? 1'b1 : eq_q) && (byte_i == ref_b);
        pass_o  = grp_now || eq_now;
    end

    // Hold the running match state over the header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= 1'b0;
            eq_q  <= 1'b0;
        end else if (byte_v_i && (idx_i < 3'd6)) begin
            grp_q <= grp_now;
            eq_q  <= eq_now;
        end
    end
endmodule

// File: rtl/rx_word_packer.sv
// Byte-to-word packer.
// Places byte n of a frame in lane n mod 4 of data word n/4 of the selected
// buffer. Emits a write on the fourth lane and on the last byte, with unfilled
// lanes set to zero. Assumes cnt_i stays below BUF_BYTES-4 whenever byte_v_i is 1.
module rx_word_packer #(
    parameter int BUF_BYTES = 2048
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              byte_v_i,
    input  logic [7:0]                        byte_i,
    input  logic                              last_i,
    input  logic [$clog2(BUF_BYTES)-1:0]      cnt_i,
    input  logic                              buf_i,
    output logic                              we_o,
    output logic [$clog2(BUF_BYTES/4):0]      waddr_o,
    output logic [31:0]                       wdata_o
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam logic [WIDX_W-1:0] CTRL_SLOT = WIDX_W'(BUF_WORDS - 1);

    logic [23:0] acc_q;
    logic [1:0]  lane;

    assign lane    = cnt_i[1:0];
    assign we_o    = byte_v_i && ((lane == 2'd3) || last_i);
    assign waddr_o = {buf_i, cnt_i[$clog2(BUF_BYTES)-1:2]};

    // Merge the incoming byte with the lanes collected so far.
    always_comb begin
        case (lane)
            2'd0:    wdata_o = {24'h0, byte_i};
            2'd1:    wdata_o = {16'h0, byte_i, acc_q[7:0]};
            2'd2:    wdata_o = {8'h0, byte_i, acc_q[15:0]};
            default: wdata_o = {byte_i, acc_q[23:0]};
        endcase
    end

    // Collect the lower three lanes of the word being built.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (byte_v_i) begin
            case (lane)
                2'd0:    acc_q[7:0]   <= byte_i;
                2'd1:    acc_q[15:8]  <= byte_i;
                2'd2:    acc_q[23:16] <= byte_i;
                default: acc_q        <= acc_q;
            endcase
        end
    end

    // R5
    ctrl_slot_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (waddr_o[WIDX_W-1:0] != CTRL_SLOT));
endmodule

// File: rtl/rx_buf_ctrl.sv
// Control words, target-buffer index and receive interrupt.
// Software writes replace a whole control word; a frame commit then sets the
// held flag, so a commit wins over a write in the same cycle. The interrupt
// is gated by buffer 0's enable bit and the global enable only.
// Assumes pp_en_i is static between resets.
module rx_buf_ctrl
    import ethrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pp_en_i,
    input  logic             gie_i,
    input  logic             sw_wr_i,
    input  logic             sw_buf_i,
    input  logic [31:0]      sw_data_i,
    input  logic             commit_i,
    input  logic             commit_buf_i,
    output logic [1:0][31:0] ctrl_o,
    output logic             act_o,
    output logic             irq_o
);
    logic [1:0][31:0] ctrl_q;
    logic [1:0][31:0] ctrl_d;
    logic             act_q;
    logic             irq_q;

    // Next control words: software value first, then the commit flag.
    always_comb begin
        ctrl_d = ctrl_q;
        if (sw_wr_i) ctrl_d[sw_buf_i] = sw_data_i;
        if (commit_i) ctrl_d[commit_buf_i][STAT_BIT] = 1'b1;
    end

    // Register control words, target index and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            act_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            irq_q  <= commit_i && ctrl_q[0][IEN_BIT] && gie_i;
            if (commit_i) act_q <= pp_en_i ? ~act_q : 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
    assign act_o  = act_q;
    assign irq_o  = irq_q;

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R6
    held_after_store0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !commit_buf_i) |=> ctrl_q[0][STAT_BIT]);

    // R6
    held_after_store1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && commit_buf_i) |=> ctrl_q[1][STAT_BIT]);

    // R8
    target_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && pp_en_i) |=> (act_q != $past(act_q)));
endmodule

// File: rtl/ethrx_pingpong_rx.sv
// Receive frame engine with two frame buffers.
// Tracks frame boundaries on the byte stream, picks the target buffer at the
// first byte, and drops frames that hit a held buffer, fail the address check,
// are shorter than a header or overrun a buffer. Holds the buffer memory and
// serves registered word reads. Assumes one byte per cycle at most and
// frames separated by rx_last.
module ethrx_pingpong_rx
    import ethrx_pkg::*;
#(
    parameter int BUF_BYTES = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [47:0]                  station_mac,
    input  logic                         pp_en,
    input  logic                         gie_en,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         rx_last,
    input  logic [$clog2(BUF_BYTES/4):0] bus_word,
    input  logic                         bus_wr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         rx_irq,
    output logic                         rx_lost
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam int BYTE_AW   = $clog2(BUF_BYTES);
    localparam int CNT_W     = BYTE_AW + 1;
    localparam int CAP       = BUF_BYTES - 4;
    localparam logic [CNT_W-1:0] CAP_C    = CNT_W'(CAP);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_BYTES - 1);

    frame_st_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_eff;
    logic             buf_q;
    logic             act;
    logic             start;
    logic             full_cur;
    logic             cur_buf;
    logic             storing;
    logic             over;
    logic             byte_ok;
    logic             fail;
    logic             commit;
    logic             pass;
    logic [2:0]       idx;
    logic [1:0][31:0] ctrl;
    logic             pk_we;
    logic [WIDX_W:0]  pk_addr;
    logic [31:0]      pk_data;
    logic             lost_q;
    logic [31:0]      rdata_q;
    logic             is_ctrl;
    logic [31:0]      mem_q [2*BUF_WORDS];

    // Decode the current byte against the frame state.
    always_comb begin
        start    = rx_valid && (st_q == FR_IDLE);
        full_cur = ctrl[act][STAT_BIT];
        cur_buf  = start ? act : buf_q;
        cnt_eff  = start ? '0 : cnt_q;
        idx      = (cnt_eff > CNT_W'(7)) ? 3'd7 : cnt_eff[2:0];
        storing  = rx_valid && (start ? !full_cur : (st_q == FR_STORE));
        over     = storing && (cnt_eff >= CAP_C);
        byte_ok  = storing && !over;
        fail     = byte_ok && (idx == 3'd5) && !pass;
        commit   = byte_ok && rx_last && !fail && (cnt_eff >= HDR_LAST);
    end

    // Advance the frame state, byte count and lost pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FR_IDLE;
            cnt_q  <= '0;
            buf_q  <= 1'b0;
            lost_q <= 1'b0;
        end else begin
            lost_q <= start && full_cur;
            if (rx_valid) begin
                if (start) buf_q <= act;
                if (byte_ok) cnt_q <= cnt_eff + 1'b1;
                if (rx_last) st_q <= FR_IDLE;
                else if (start) st_q <= full_cur ? FR_DROP : FR_STORE;
                else if (fail || over) st_q <= FR_DROP;
            end
        end
    end

    rx_dest_filter u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_v_i (byte_ok),
        .idx_i    (idx),
        .byte_i   (rx_data),
        .mac_i    (station_mac),
        .pass_o   (pass)
    );

    rx_word_packer #(.BUF_BYTES(BUF_BYTES)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_v_i (byte_ok),
        .byte_i   (rx_data),
        .last_i   (rx_last),
        .cnt_i    (cnt_eff[BYTE_AW-1:0]),
        .buf_i    (cur_buf),
        .we_o     (pk_we),
        .waddr_o  (pk_addr),
        .wdata_o  (pk_data)
    );

    assign is_ctrl = &bus_word[WIDX_W-1:0];

    rx_buf_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pp_en_i      (pp_en),
        .gie_i        (gie_en),
        .sw_wr_i      (bus_wr && is_ctrl),
        .sw_buf_i     (bus_word[WIDX_W]),
        .sw_data_i    (bus_wdata),
        .commit_i     (commit),
        .commit_buf_i (cur_buf),
        .ctrl_o       (ctrl),
        .act_o        (act),
        .irq_o        (rx_irq)
    );

    // Write packed words into the buffer memory.
    always_ff @(posedge clk) begin
        if (pk_we) mem_q[pk_addr] <= pk_data;
    end

    // Registered read of a control word or a data word.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= is_ctrl ? ctrl[bus_word[WIDX_W]] : mem_q[bus_word];
    end

    assign bus_rdata = rdata_q;
    assign rx_lost   = lost_q;

    // R4
    lost_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && full_cur) |-> !pk_we);
endmodule

// File: tb/tb_ethrx_pingpong_rx.sv
module tb_ethrx_pingpong_rx;
    localparam int BUF_BYTES = 2048;
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int CAP       = BUF_BYTES - 4;
    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pp_en = 1'b1;
    logic        gie_en = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic [9:0]  bus_word = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_irq;
    logic        rx_lost;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int lost_seen = 0;

    // behavioural reference state
    logic [31:0] m_ctrl [2];
    logic [31:0] o0, o1;
    logic [7:0]  m_mem [2][BUF_BYTES];
    logic [7:0]  fq[$];
    logic [7:0]  tx_q[$];
    int          m_act, m_buf;
    bit          m_infr, m_fs, e_irq, e_lost, do_set;

    always #2 clk = ~clk;

    ethrx_pingpong_rx #(.BUF_BYTES(BUF_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .station_mac(MAC), .pp_en(pp_en), .gie_en(gie_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .bus_word(bus_word), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_irq(rx_irq), .rx_lost(rx_lost)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit frame_ok();
        bit eq = 1'b1;
        if (m_fs || fq.size() < 6 || fq.size() > CAP) return 1'b0;
        for (int k = 0; k < 6; k++) if (fq[k] != MAC[47-8*k -: 8]) eq = 1'b0;
        return fq[0][7] || eq;
    endfunction

    // reference model, stepped and compared every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl[0] = '0; m_ctrl[1] = '0; m_act = 0; m_infr = 0;
            e_irq = 0; e_lost = 0;
        end else begin
            o0 = m_ctrl[0]; o1 = m_ctrl[1];
            e_irq = 0; e_lost = 0; do_set = 0;
            if (rx_valid) begin
                if (!m_infr) begin
                    m_infr = 1; fq.delete(); m_buf = m_act;
                    m_fs = (m_act == 0) ? o0[0] : o1[0];
                    e_lost = m_fs;
                end
                fq.push_back(rx_data);
                if (rx_last) begin
                    m_infr = 0;
                    if (frame_ok()) begin
                        for (int k = 0; k < fq.size(); k++) m_mem[m_buf][k] = fq[k];
                        for (int k = fq.size(); (k % 4) != 0; k++) m_mem[m_buf][k] = 8'h00;
                        do_set = 1;
                        e_irq = o0[3] && gie_en;
                        m_act = pp_en ? (m_act ^ 1) : 0;
                    end
                end
            end
            if (bus_wr && (bus_word[8:0] == 9'h1FF)) m_ctrl[bus_word[9]] = bus_wdata;
            if (do_set) m_ctrl[m_buf][0] = 1'b1;
        end
        #1;
        if (rst_n) begin
            chk(rx_irq == e_irq, "R7 per-cycle irq", 32'(rx_irq), 32'(e_irq));
            chk(rx_lost == e_lost, "R4 per-cycle lost", 32'(rx_lost), 32'(e_lost));
            if (rx_irq) irq_seen++;
            if (rx_lost) lost_seen++;
        end
    end

    task automatic rd(input int b, input int w, output logic [31:0] v);
        @(negedge clk);
        bus_word = 10'(b * BUF_WORDS + w);
        @(posedge clk);
        #1 v = bus_rdata;
    endtask

    task automatic chk_ctrl(input int b, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(b, BUF_WORDS - 1, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic chk_word(input int b, input int w, input string req);
        logic [31:0] v, e;
        e = {m_mem[b][4*w+3], m_mem[b][4*w+2], m_mem[b][4*w+1], m_mem[b][4*w]};
        rd(b, w, v);
        chk(v == e, req, v, e);
    endtask

    task automatic wr(input int b, input logic [31:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = 10'(b * BUF_WORDS + BUF_WORDS - 1); bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic mk(input logic [47:0] dst, input int len, input logic [7:0] base);
        tx_q.delete();
        for (int k = 0; k < len; k++)
            if (k < 6) tx_q.push_back(dst[47-8*k -: 8]);
            else tx_q.push_back(base + 8'(k));
    endtask

    task automatic send();
        for (int i = 0; i < tx_q.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = tx_q[i]; rx_last = (i == tx_q.size() - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_ctrl(0, 32'h0, "R1 ctrl0 reset");
        chk_ctrl(1, 32'h0, "R1 ctrl1 reset");
        chk(rx_irq == 1'b0, "R1 irq reset", 32'(rx_irq), 32'h0);
        // R10 write stores value
        wr(0, 32'h8);
        chk_ctrl(0, 32'h8, "R10 readback");
        // R3 matching unicast into buffer 0
        mk(MAC, 13, 8'h40); send();
        chk_ctrl(0, 32'h9, "R6 buf0 held");
        for (int w = 0; w < 4; w++) chk_word(0, w, "R9 buf0 data");
        begin
            logic [31:0] v;
            rd(0, 3, v);
            chk(v == 32'h0000_004C, "R9 partial word", v, 32'h0000_004C);
        end
        chk(irq_seen == 1, "R7 irq count", 32'(irq_seen), 32'd1);
        // R2 group frame goes to buffer 1 (R8 alternation)
        mk(48'h81_00_00_00_00_07, 8, 8'h70); send();
        chk_ctrl(1, 32'h1, "R8 buf1 held");
        chk_ctrl(0, 32'h9, "R8 buf0 kept");
        chk_word(1, 0, "R2 group data");
        chk_word(1, 1, "R2 group data");
        chk(irq_seen == 2, "R7 irq from buf1", 32'(irq_seen), 32'd2);
        // R4 both held: frame lost
        mk(MAC, 10, 8'h20); send();
        chk(lost_seen == 1, "R4 lost count", 32'(lost_seen), 32'd1);
        chk_ctrl(0, 32'h9, "R4 ctrl0 unchanged");
        // R10 release buffer 0, R3 mismatch dropped
        wr(0, 32'h8);
        mk(48'h02_11_22_33_44_56, 10, 8'h00); send();
        chk_ctrl(0, 32'h8, "R3 mismatch dropped");
        // R11 short group frame dropped
        mk(48'hFF_FF_FF_FF_FF_FF, 4, 8'h00); send();
        chk_ctrl(0, 32'h8, "R11 short dropped");
        // six-byte frame lands in buffer 0: target kept through drops
        mk(MAC, 6, 8'h00); send();
        chk_ctrl(0, 32'h9, "R3 target kept");
        chk_word(0, 0, "R9 six-byte w0");
        begin
            logic [31:0] v;
            rd(0, 1, v);
            chk(v == 32'h0000_5544, "R9 six-byte w1", v, 32'h0000_5544);
        end
        // R5 oversize then exact capacity in buffer 1
        wr(1, 32'h0);
        mk(MAC, CAP + 1, 8'h33); send();
        chk_ctrl(1, 32'h0, "R5 oversize dropped");
        mk(48'h81_00_00_00_00_07, CAP, 8'h10); send();
        chk_ctrl(1, 32'h1, "R5 capacity stored");
        chk_word(1, BUF_WORDS - 2, "R5 last data word");
        chk_word(1, 0, "R9 buf1 word0");
        chk(irq_seen == 4, "R7 irq count", 32'(irq_seen), 32'd4);
        // R7 global enable off
        gie_en = 1'b0;
        wr(0, 32'h8);
        mk(MAC, 20, 8'h55); send();
        chk(irq_seen == 4, "R7 gie gates irq", 32'(irq_seen), 32'd4);
        chk_ctrl(0, 32'h9, "R6 held without irq");
        gie_en = 1'b1;
        // R7 buffer-0 enable off, frame into buffer 1
        wr(1, 32'h0);
        wr(0, 32'h1);
        chk_ctrl(0, 32'h1, "R10 raw store");
        mk(MAC, 9, 8'h61); send();
        chk(irq_seen == 4, "R7 enable bit gates irq", 32'(irq_seen), 32'd4);
        chk_ctrl(1, 32'h1, "R6 buf1 held");
        // single-buffer mode
        @(negedge clk);
        rst_n = 1'b0; pp_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_ctrl(0, 32'h0, "R1 ctrl0 after reset");
        wr(0, 32'h8);
        mk(MAC, 9, 8'h01); send();
        chk_ctrl(0, 32'h9, "R8 single mode buf0");
        wr(0, 32'h8);
        mk(48'h81_00_00_00_00_07, 7, 8'h02); send();
        chk_ctrl(0, 32'h9, "R8 single mode buf0 again");
        chk_ctrl(1, 32'h0, "R8 buf1 unused");
        chk_word(0, 1, "R9 single mode data");
        mk(MAC, 9, 8'h03); send();
        chk(lost_seen == 2, "R4 lost single mode", 32'(lost_seen), 32'd2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule